// File: doc/BRIEF.md
# Indirect Regulator Field Programmer

This block is a bus master that changes one bit field inside a regulator-control word. The word cannot be addressed directly. It sits behind a pair of registers on a simple 32-bit register bus: an index register that selects which control word is visible, and a data register that exposes the selected word. A client hands the block a symbolic voltage identifier and a value. The block looks up where that identifier's field lives, then performs a fixed read-modify-write through the index/data window. Only the bits of the selected field change.

The bus sequence includes throw-away reads before and after the real accesses. The downstream register logic relies on these reads, so the block always issues them. Requests arrive on a valid/ready handshake. The block ends each request with a one-cycle done pulse. If the identifier is unknown, it instead ends the request with a one-cycle error pulse and makes no bus access.

Top module: `regfield_prog`

## Requirements
- R1: After reset, req_ready is 1, and bus_req, done and err are all 0.
- R2: An accepted request with a known identifier produces exactly six bus accesses, in this order:
  1. read of the index register (result discarded);
  2. write of the field's word index to the index register;
  3. read of the index register (result discarded);
  4. read of the data register;
  5. write of the merged word to the data register;
  6. read of the data register (result discarded).

  The index register is at bus address 0x00 and the data register at 0x04. bus_we is 1 for writes.
- R3: Identifier 1 selects word index 2, field bits [28:25] (4 bits).
- R4: Identifier 2 selects word index 3, bits [4:1]. Identifier 3 selects word index 3, bits [12:9]. Both fields are 4 bits wide.
- R5: Identifier 4 (the PA reference) selects word index 3, bits [22:17] (6 bits).
- R6: The written word equals the word read from the data register, with only the field bits replaced. The replacement is the request value truncated to the field width.
- R7: An identifier outside 1..4 (0, 5, 6, 7) produces a one-cycle err pulse in the cycle after acceptance. It makes no bus access, and req_ready stays 1.
- R8: req_ready is 0 from the cycle after acceptance until done. A request presented while a sequence runs is not taken.
- R9: Each access keeps bus_req, bus_we, bus_addr and bus_wdata steady until bus_ack. A stalled bus lengthens each access by exactly its wait cycles.
- R10: done is a one-cycle pulse in the cycle after the final access is acknowledged. With a zero-wait bus, done appears 12 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_id | input | 3 | Voltage identifier |
| req_value | input | 32 | New field value (truncated to field width) |
| done | output | 1 | One-cycle pulse when the sequence completes |
| err | output | 1 | One-cycle pulse for an unknown identifier |
| bus_req | output | 1 | Bus access pending |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Bus address (index or data register) |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completion, one cycle |

## Verification
The hardest situation to reach from the ports is a second request arriving while a sequence is mid-flight, close to the done cycle. That is where a careless ready could let it slip in.

The bench slows its bus model to several wait cycles per access. It holds a competing request valid for the whole sequence, and drops it only in the cycle where done is seen. It then confirms from the bus log and from the modelled register contents that only the first field was touched. The stalled-bus run also shows that the completion time grows by exactly the injected wait cycles.

// File: rtl/regfield_pkg.sv
package regfield_pkg;

    localparam int IDX_W   = 4;
    localparam int SHIFT_W = 5;
    localparam int MASK_W  = 6;
    localparam int ID_W    = 3;

    localparam logic [ID_W-1:0] ID_VOLT1 = 3'd1;
    localparam logic [ID_W-1:0] ID_VOLT2 = 3'd2;
    localparam logic [ID_W-1:0] ID_VOLT3 = 3'd3;
    localparam logic [ID_W-1:0] ID_PAREF = 3'd4;

    typedef struct packed {
        logic               hit;
        logic [IDX_W-1:0]   idx;
        logic [SHIFT_W-1:0] shift;
        logic [MASK_W-1:0]  mask;
    } field_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEEK_IDX,
        ST_SET_IDX,
        ST_CHK_IDX,
        ST_LOAD,
        ST_STORE,
        ST_FLUSH
    } seq_e;

endpackage

// File: rtl/regfield_lut.sv
module regfield_lut
    import regfield_pkg::*;
(
    input  logic [ID_W-1:0] id,
    output field_t          fld
);
    always_comb begin
        fld = '0;
        unique case (id)
            ID_VOLT1: fld = '{hit: 1'b1, idx: 4'd2, shift: 5'd25, mask: 6'h0F};
            ID_VOLT2: fld = '{hit: 1'b1, idx: 4'd3, shift: 5'd1,  mask: 6'h0F};
            ID_VOLT3: fld = '{hit: 1'b1, idx: 4'd3, shift: 5'd9,  mask: 6'h0F};
            ID_PAREF: fld = '{hit: 1'b1, idx: 4'd3, shift: 5'd17, mask: 6'h3F};
            default:  fld = '0;
        endcase
    end
endmodule

// File: rtl/regfield_merge.sv
module regfield_merge
    import regfield_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  old_word,
    input  logic [DATA_W-1:0]  new_val,
    input  logic [MASK_W-1:0]  mask,
    input  logic [SHIFT_W-1:0] shift,
    output logic [DATA_W-1:0]  merged
);
    logic [DATA_W-1:0] place_mask;
    logic [DATA_W-1:0] place_val;

    assign place_mask = DATA_W'(mask) << shift;
    assign place_val  = (new_val & DATA_W'(mask)) << shift;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign merged[b] = place_mask[b] ? place_val[b] : old_word[b];
    end
endmodule

// File: rtl/regfield_prog.sv
module regfield_prog
    import regfield_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 8'h00,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [DATA_W-1:0] req_value,
    output logic              done,
    output logic              err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    typedef struct packed {
        seq_e              st;
        field_t            fld;
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] merged;
        logic              done;
        logic              err;
    } state_t;

    state_t            s_d, s_q;
    field_t            lut_fld;
    logic [DATA_W-1:0] merge_out;

    regfield_lut u_lut (
        .id  (req_id),
        .fld (lut_fld)
    );

    regfield_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word (bus_rdata),
        .new_val  (s_q.val),
        .mask     (s_q.fld.mask),
        .shift    (s_q.fld.shift),
        .merged   (merge_out)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (lut_fld.hit) begin
                        s_d.st  = ST_PEEK_IDX;
                        s_d.fld = lut_fld;
                        s_d.val = req_value;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            ST_PEEK_IDX: if (bus_ack) s_d.st = ST_SET_IDX;
            ST_SET_IDX:  if (bus_ack) s_d.st = ST_CHK_IDX;
            ST_CHK_IDX:  if (bus_ack) s_d.st = ST_LOAD;
            ST_LOAD: begin
                if (bus_ack) begin
                    s_d.merged = merge_out;
                    s_d.st     = ST_STORE;
                end
            end
            ST_STORE:    if (bus_ack) s_d.st = ST_FLUSH;
            ST_FLUSH: begin
                if (bus_ack) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default:     s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, fld: '0, val: '0, merged: '0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_req   = (s_q.st != ST_IDLE);
        bus_we    = (s_q.st == ST_SET_IDX) || (s_q.st == ST_STORE);
        bus_addr  = ((s_q.st == ST_PEEK_IDX) || (s_q.st == ST_SET_IDX) ||
                     (s_q.st == ST_CHK_IDX)) ? IDX_ADDR : DAT_ADDR;
        bus_wdata = '0;
        if (s_q.st == ST_SET_IDX) bus_wdata = DATA_W'(s_q.fld.idx);
        else if (s_q.st == ST_STORE) bus_wdata = s_q.merged;
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign done      = s_q.done;
    assign err       = s_q.err;

endmodule

// File: rtl/regfield_prog_chk.sv
module regfield_prog_chk #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 8'h00,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 8'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              err,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack
);
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready); // R8

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bus_req && req_ready); // R7

    AST_DONE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_req && bus_ack && !bus_we && bus_addr == DAT_ADDR)); // R10

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err})); // R10

    AST_INDEX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == IDX_ADDR |-> (bus_wdata == 2 || bus_wdata == 3)); // R3
endmodule

bind regfield_prog regfield_prog_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .err(err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/tb_regfield_prog.sv
`timescale 1ns/1ps
module tb_regfield_prog;
    localparam logic [7:0] IDX_A = 8'h00;
    localparam logic [7:0] DAT_A = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_id = '0;
    logic [31:0] req_value = '0;
    logic        done, err;
    logic        bus_req, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    regfield_prog dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_value(req_value), .done(done), .err(err),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // bus slave model with index/data window and an access log
    int          lat = 0;
    int          wcnt;
    logic [31:0] regs [0:15];
    logic [3:0]  sel;
    logic        log_we   [0:15];
    logic [7:0]  log_addr [0:15];
    logic [31:0] log_data [0:15];
    int          log_n;
    logic        pre_en = 1'b0;
    logic [3:0]  pre_idx = '0;
    logic [31:0] pre_val = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            wcnt      <= 0;
            sel       <= '0;
            log_n     <= 0;
            for (int i = 0; i < 16; i++) regs[i] <= '0;
        end else begin
            bus_ack <= 1'b0;
            if (pre_en) begin
                regs[pre_idx] <= pre_val;
                log_n         <= 0;
            end else if (bus_req && !bus_ack) begin
                if (wcnt >= lat) begin
                    wcnt    <= 0;
                    bus_ack <= 1'b1;
                    if (log_n < 16) begin
                        log_we[log_n]   <= bus_we;
                        log_addr[log_n] <= bus_addr;
                        log_data[log_n] <= bus_we ? bus_wdata :
                                           (bus_addr == IDX_A ? 32'(sel) : regs[sel]);
                    end
                    log_n <= log_n + 1;
                    if (bus_we) begin
                        if (bus_addr == IDX_A) sel <= bus_wdata[3:0];
                        else regs[sel] <= bus_wdata;
                    end else begin
                        bus_rdata <= (bus_addr == IDX_A) ? 32'(sel) : regs[sel];
                    end
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] pre, input logic [31:0] val,
                                                input int sh, input int w);
        logic [31:0] m;
        m = (32'd1 << w) - 32'd1;
        return (pre & ~(m << sh)) | ((val & m) << sh);
    endfunction

    task automatic preload(input int idx, input logic [31:0] v);
        @(negedge clk);
        pre_en = 1'b1; pre_idx = 4'(idx); pre_val = v;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic run_req(input logic [2:0] id, input logic [31:0] v,
                           output bit got_done, output bit got_err, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_value = v;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!(done || err) && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        got_done = done;
        got_err  = err;
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        check(bus_req == 1'b0, "R1 bus_req", 32'(bus_req), 32'd0);
        check(done == 1'b0, "R1 done", 32'(done), 32'd0);
        check(err == 1'b0, "R1 err", 32'(err), 32'd0);
    endtask

    task automatic t_rmw(input string tag, input logic [2:0] id, input logic [31:0] v,
                         input int idx, input int sh, input int w, input logic [31:0] pre);
        bit d, e; int cyc; logic [31:0] ex; int other;
        other = (idx == 2) ? 3 : 2;
        lat = 0;
        preload(other, 32'h5A5A_0F0F);
        preload(idx, pre);
        ex = expect_word(pre, v, sh, w);
        run_req(id, v, d, e, cyc);
        check(d && !e, {tag, " R2 done"}, {30'd0, d, e}, 32'd2);
        check(cyc == 12, {tag, " R10 latency"}, 32'(cyc), 32'd12);
        check(log_n == 6, {tag, " R2 access count"}, 32'(log_n), 32'd6);
        check(!log_we[0] && log_addr[0] == IDX_A, {tag, " R2 step1"}, {log_we[0], log_addr[0]}, {1'b0, IDX_A});
        check(log_we[1] && log_addr[1] == IDX_A && log_data[1] == 32'(idx),
              {tag, " index write"}, log_data[1], 32'(idx));
        check(!log_we[2] && log_addr[2] == IDX_A, {tag, " R2 step3"}, {log_we[2], log_addr[2]}, {1'b0, IDX_A});
        check(!log_we[3] && log_addr[3] == DAT_A && log_data[3] == pre, {tag, " R2 load"}, log_data[3], pre);
        check(log_we[4] && log_addr[4] == DAT_A && log_data[4] == ex, {tag, " R6 merged"}, log_data[4], ex);
        check(!log_we[5] && log_addr[5] == DAT_A, {tag, " R2 step6"}, {log_we[5], log_addr[5]}, {1'b0, DAT_A});
        check(regs[other] == 32'h5A5A_0F0F, {tag, " R6 other word"}, regs[other], 32'h5A5A_0F0F);
        @(negedge clk);
        check(done == 1'b0, {tag, " R10 pulse width"}, 32'(done), 32'd0);
    endtask

    task automatic t_bad_id(input logic [2:0] id);
        bit d, e; int cyc;
        preload(3, 32'h0);
        run_req(id, 32'hFFFF_FFFF, d, e, cyc);
        check(e && !d && cyc == 0, "R7 err timing", {16'(cyc), 14'd0, d, e}, 32'd1);
        check(req_ready == 1'b1, "R7 ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        check(err == 1'b0, "R7 err width", 32'(err), 32'd0);
        repeat (3) @(negedge clk);
        check(log_n == 0, "R7 no bus access", 32'(log_n), 32'd0);
    endtask

    task automatic t_stall;
        bit d, e; int cyc;
        preload(2, 32'h0);
        lat = 3;
        run_req(3'd1, 32'h9, d, e, cyc);
        check(d && cyc == 30, "R9 stalled latency", 32'(cyc), 32'd30);
        check(regs[2] == 32'h1200_0000, "R9 stalled result", regs[2], 32'h1200_0000);
        lat = 0;
    endtask

    task automatic t_busy;
        int cyc; bit low_ok;
        preload(3, 32'h0);
        lat = 2;
        @(negedge clk);
        req_valid = 1'b1; req_id = 3'd2; req_value = 32'h7;
        @(negedge clk);
        req_id = 3'd3; req_value = 32'hF;
        cyc = 0; low_ok = 1'b1;
        while (!done && cyc < 400) begin
            if (req_ready) low_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check(low_ok, "R8 ready low while busy", 32'(low_ok), 32'd1);
        repeat (20) @(negedge clk);
        check(log_n == 6, "R8 second request refused", 32'(log_n), 32'd6);
        check(regs[3] == 32'h0000_000E, "R8 only first field", regs[3], 32'h0000_000E);
        lat = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rmw("R3 id1", 3'd1, 32'hFFFF_FFF5, 2, 25, 4, 32'hA5A5_A5A5);
        t_rmw("R4 id2", 3'd2, 32'h0000_000C, 3, 1, 4, 32'hFFFF_FFFF);
        t_rmw("R4 id3", 3'd3, 32'h0000_0003, 3, 9, 4, 32'h0000_0000);
        t_rmw("R5 paref", 3'd4, 32'h0001_00FF, 3, 17, 6, 32'h1234_5678);
        t_bad_id(3'd0);
        t_bad_id(3'd5);
        t_bad_id(3'd7);
        t_stall();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule